// File: doc/BRIEF.md
# Virtual Wire Receive Register Bank

This block keeps the received state of a small set of sideband virtual wires. Each update is an index byte and a data byte, qualified by a single-cycle strobe. The upper nibble of the data byte is a per-bit qualifier mask. The lower nibble carries the new levels. A level bit moves only when its own qualifier is set. Every other bit keeps its earlier value, so several packets that each carry one qualified bit add up to the full state of an index.

For each bit, the bank also keeps a sticky "seen" flag. The flag is set the first time that bit arrives qualified, and later packets never clear it. A combinational read port returns both the level and the seen flags of any index. A one-cycle change pulse, together with the index, reports every accepted packet that really changed a level. A one-cycle error pulse reports packets addressed to an index the bank does not implement. The link reset returns every level to its per-index default and clears all seen flags.

Top module: `vw_rx_bank`

## Requirements
- R1: For an accepted packet, data bit n+4 set (n = 0..3) loads data bit n into level bit n of the addressed index.
- R2: For an accepted packet, a level bit whose qualifier (data bit n+4) is 0 keeps its previous value.
- R3: Starting from level 0 on index 2, the packets 0x11, 0x23 and 0x47 leave index 2 reading level 0x7 with seen flags 0x7.
- R4: A seen bit is set by any packet whose qualifier for that bit is 1, whatever the level carried, and only reset clears it.
- R5: While rst_n is low, every index reads its default nibble from DEFAULT_LVL (index i in bits 4i+3:4i), every seen flag reads 0, and both pulses are 0.
- R6: A strobed packet whose index is NUM_IDX or above changes no state, and err_pulse is 1 for exactly the following cycle.
- R7: chg_pulse is 1 for the cycle after an accepted packet that changed at least one level bit, with chg_idx equal to that packet's index. It stays 0 when no level bit changed.
- R8: rd_level and rd_seen come combinationally from stored state, so a read in the same cycle as a write to that index returns the value held before the write.
- R9: With wr_stb low, the index and data inputs have no effect on any stored state.
- R10: A read of an unimplemented index returns 0 on both rd_level and rd_seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low link reset |
| wr_stb | input | 1 | Packet strobe |
| wr_idx | input | IDX_W | Packet index |
| wr_data | input | 8 | Qualifier mask [7:4], levels [3:0] |
| rd_idx | input | IDX_W | Read index |
| rd_level | output | 4 | Stored levels of rd_idx |
| rd_seen | output | 4 | Sticky seen flags of rd_idx |
| chg_pulse | output | 1 | A level changed in the previous cycle |
| chg_idx | output | IDX_W | Index that changed |
| err_pulse | output | 1 | The previous packet hit an unimplemented index |

## Verification
The hardest situation to reach is a qualified bit that carries the level the bit already holds. Such a packet must set the seen flag and leave the level unchanged, without raising a change pulse. The stimulus reaches it by first building up index 2 through single-bit packets. It then sends a packet that qualifies only bit 3 with level 0. Unqualified packets, out-of-range packets and unstrobed data follow, and each is checked through the read port and the two pulses.

// File: rtl/vw_rx_pkg.sv
package vw_rx_pkg;

    localparam int LVL_W  = 4;
    localparam int DATA_W = 2 * LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        lvl_t qual;
        lvl_t lvl;
    } vw_byte_t;

endpackage

// File: rtl/vw_rx_decode.sv
module vw_rx_decode #(
    parameter int NUM_IDX = 8,
    parameter int IDX_W   = 8
) (
    input  logic               stb,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_IDX-1:0] sel,
    output logic               hit,
    output logic               miss
);

    for (genvar i = 0; i < NUM_IDX; i++) begin : g_sel
        assign sel[i] = stb && (idx == IDX_W'(i));
    end

    assign hit  = |sel;
    assign miss = stb && !hit;

endmodule

// File: rtl/vw_rx_merge.sv
module vw_rx_merge
    import vw_rx_pkg::*;
(
    input  logic     en,
    input  vw_byte_t pkt,
    input  lvl_t     cur_lvl,
    input  lvl_t     cur_seen,
    output lvl_t     nxt_lvl,
    output lvl_t     nxt_seen,
    output logic     changed
);

    lvl_t mask;

    always_comb begin
        mask     = en ? pkt.qual : '0;
        nxt_lvl  = (cur_lvl & ~mask) | (pkt.lvl & mask);
        nxt_seen = cur_seen | mask;
        changed  = (nxt_lvl != cur_lvl);
    end

endmodule

// File: rtl/vw_rx_rdmux.sv
module vw_rx_rdmux
    import vw_rx_pkg::*;
#(
    parameter int NUM_IDX = 8,
    parameter int IDX_W   = 8
) (
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [NUM_IDX-1:0][LVL_W-1:0] lvl_arr,
    input  logic [NUM_IDX-1:0][LVL_W-1:0] seen_arr,
    output lvl_t                          rd_level,
    output lvl_t                          rd_seen
);

    always_comb begin
        rd_level = '0;
        rd_seen  = '0;
        for (int i = 0; i < NUM_IDX; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_level = lvl_arr[i];
                rd_seen  = seen_arr[i];
            end
        end
    end

endmodule

// File: rtl/vw_rx_bank.sv
module vw_rx_bank
    import vw_rx_pkg::*;
#(
    parameter int                         NUM_IDX     = 8,
    parameter int                         IDX_W       = 8,
    parameter logic [NUM_IDX*LVL_W-1:0]   DEFAULT_LVL = 32'h8000_A005
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [LVL_W-1:0]   rd_level,
    output logic [LVL_W-1:0]   rd_seen,
    output logic               chg_pulse,
    output logic [IDX_W-1:0]   chg_idx,
    output logic               err_pulse
);

    typedef struct packed {
        logic [NUM_IDX-1:0][LVL_W-1:0] lvl;
        logic [NUM_IDX-1:0][LVL_W-1:0] seen;
        logic                          chg;
        logic [IDX_W-1:0]              chg_idx;
        logic                          err;
    } state_t;

    localparam state_t RST_STATE = '{
        lvl:     DEFAULT_LVL,
        seen:    '0,
        chg:     1'b0,
        chg_idx: '0,
        err:     1'b0
    };

    state_t state_d, state_q;

    logic [NUM_IDX-1:0]            sel;
    logic                          hit;
    logic                          miss;
    logic [NUM_IDX-1:0][LVL_W-1:0] nxt_lvl;
    logic [NUM_IDX-1:0][LVL_W-1:0] nxt_seen;
    logic [NUM_IDX-1:0]            changed;
    vw_byte_t                      pkt;

    assign pkt = vw_byte_t'(wr_data);

    vw_rx_decode #(
        .NUM_IDX (NUM_IDX),
        .IDX_W   (IDX_W)
    ) u_decode (
        .stb  (wr_stb),
        .idx  (wr_idx),
        .sel  (sel),
        .hit  (hit),
        .miss (miss)
    );

    for (genvar i = 0; i < NUM_IDX; i++) begin : g_entry
        vw_rx_merge u_merge (
            .en       (sel[i]),
            .pkt      (pkt),
            .cur_lvl  (state_q.lvl[i]),
            .cur_seen (state_q.seen[i]),
            .nxt_lvl  (nxt_lvl[i]),
            .nxt_seen (nxt_seen[i]),
            .changed  (changed[i])
        );
    end

    always_comb begin
        state_d         = state_q;
        state_d.lvl     = nxt_lvl;
        state_d.seen    = nxt_seen;
        state_d.chg     = hit && (|changed);
        state_d.chg_idx = (hit && (|changed)) ? wr_idx : '0;
        state_d.err     = miss;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    vw_rx_rdmux #(
        .NUM_IDX (NUM_IDX),
        .IDX_W   (IDX_W)
    ) u_rdmux (
        .rd_idx   (rd_idx),
        .lvl_arr  (state_q.lvl),
        .seen_arr (state_q.seen),
        .rd_level (rd_level),
        .rd_seen  (rd_seen)
    );

    assign chg_pulse = state_q.chg;
    assign chg_idx   = state_q.chg_idx;
    assign err_pulse = state_q.err;

endmodule

// File: rtl/vw_rx_bank_chk.sv
module vw_rx_bank_chk #(
    parameter int NUM_IDX = 8,
    parameter int IDX_W   = 8,
    parameter int LVL_W   = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_stb,
    input logic [IDX_W-1:0]         wr_idx,
    input logic                     chg_pulse,
    input logic [IDX_W-1:0]         chg_idx,
    input logic                     err_pulse,
    input logic [NUM_IDX*LVL_W-1:0] lvl_flat,
    input logic [NUM_IDX*LVL_W-1:0] seen_flat
);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(lvl_flat) && $stable(seen_flat)));

    // R4
    seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(seen_flat) & ~seen_flat) == '0));

    // R6
    miss_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (wr_idx >= IDX_W'(NUM_IDX))) |=>
            ($stable(lvl_flat) && $stable(seen_flat) && err_pulse));

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ($past(wr_stb) && ($past(wr_idx) >= IDX_W'(NUM_IDX))));

    // R7
    chg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> ($past(wr_stb) && (chg_idx == $past(wr_idx))
                       && (lvl_flat != $past(lvl_flat))));

    // R7
    chg_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_flat != $past(lvl_flat)) |-> chg_pulse);

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_pulse && err_pulse));

endmodule

bind vw_rx_bank vw_rx_bank_chk #(
    .NUM_IDX (NUM_IDX),
    .IDX_W   (IDX_W),
    .LVL_W   (vw_rx_pkg::LVL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_idx    (wr_idx),
    .chg_pulse (chg_pulse),
    .chg_idx   (chg_idx),
    .err_pulse (err_pulse),
    .lvl_flat  (state_q.lvl),
    .seen_flat (state_q.seen)
);

// File: tb/vw_rx_bank_bench.sv
module vw_rx_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 13;

    // {stb, idx, data, rd_idx, exp_lvl, exp_seen, exp_chg, exp_err}
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b1, 8'd2,   8'h11, 8'd2,   4'h1, 4'h1, 1'b1, 1'b0}, // R1
        {1'b1, 8'd2,   8'h23, 8'd2,   4'h3, 4'h3, 1'b1, 1'b0}, // R2
        {1'b1, 8'd2,   8'h47, 8'd2,   4'h7, 4'h7, 1'b1, 1'b0}, // R3
        {1'b1, 8'd2,   8'h08, 8'd2,   4'h7, 4'h7, 1'b0, 1'b0}, // R2
        {1'b1, 8'd2,   8'h80, 8'd2,   4'h7, 4'hF, 1'b0, 1'b0}, // R4
        {1'b1, 8'd2,   8'h10, 8'd2,   4'h6, 4'hF, 1'b1, 1'b0}, // R1
        {1'b1, 8'd0,   8'hF0, 8'd0,   4'h0, 4'hF, 1'b1, 1'b0}, // R1
        {1'b1, 8'd3,   8'hF5, 8'd3,   4'h5, 4'hF, 1'b1, 1'b0}, // R7
        {1'b1, 8'd8,   8'hFF, 8'd8,   4'h0, 4'h0, 1'b0, 1'b1}, // R10
        {1'b1, 8'd200, 8'hFF, 8'd7,   4'h8, 4'h0, 1'b0, 1'b1}, // R6
        {1'b0, 8'd7,   8'hFF, 8'd7,   4'h8, 4'h0, 1'b0, 1'b0}, // R9
        {1'b1, 8'd7,   8'hFF, 8'd7,   4'hF, 4'hF, 1'b1, 1'b0}, // R7
        {1'b1, 8'd1,   8'h22, 8'd1,   4'h2, 4'h2, 1'b1, 1'b0}  // R1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_idx = '0;
    logic [3:0] rd_level;
    logic [3:0] rd_seen;
    logic       chg_pulse;
    logic [7:0] chg_idx;
    logic       err_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vw_rx_bank u_vw_rx_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_level  (rd_level),
        .rd_seen   (rd_seen),
        .chg_pulse (chg_pulse),
        .chg_idx   (chg_idx),
        .err_pulse (err_pulse)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_read(input string req, input logic [7:0] idx,
                              input logic [3:0] lvl, input logic [3:0] seen);
        rd_idx = idx;
        #1;
        check({req, " level"}, {4'h0, rd_level}, {4'h0, lvl});
        check({req, " seen"},  {4'h0, rd_seen},  {4'h0, seen});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5 reset state
        check_read("R5 idx0", 8'd0, 4'h5, 4'h0);
        check_read("R5 idx3", 8'd3, 4'hA, 4'h0);
        check_read("R5 idx7", 8'd7, 4'h8, 4'h0);
        check("R5 chg", {7'd0, chg_pulse}, 8'd0);
        check("R5 err", {7'd0, err_pulse}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            wr_stb  = VEC[k][34];
            wr_idx  = VEC[k][33:26];
            wr_data = VEC[k][25:18];
            rd_idx  = VEC[k][17:10];
            @(negedge clk);
            wr_stb = 1'b0;
            check($sformatf("vec%0d level", k), {4'h0, rd_level}, {4'h0, VEC[k][9:6]});
            check($sformatf("vec%0d seen", k),  {4'h0, rd_seen},  {4'h0, VEC[k][5:2]});
            check($sformatf("vec%0d R7 chg", k), {7'd0, chg_pulse}, {7'd0, VEC[k][1]});
            check($sformatf("vec%0d R6 err", k), {7'd0, err_pulse}, {7'd0, VEC[k][0]});
            if (VEC[k][1])
                check($sformatf("vec%0d R7 chg_idx", k), chg_idx, VEC[k][33:26]);
        end

        // pulses last one cycle (R6, R7)
        @(negedge clk);
        check("R7 pulse width", {7'd0, chg_pulse}, 8'd0);

        // R8 same-cycle read returns the old value
        wr_stb = 1'b1; wr_idx = 8'd1; wr_data = 8'h11; rd_idx = 8'd1;
        #1;
        check("R8 old level", {4'h0, rd_level}, 8'h02);
        @(negedge clk);
        wr_stb = 1'b0;
        check("R8 new level", {4'h0, rd_level}, 8'h03);

        // R6 error pulse lasts one cycle
        wr_stb = 1'b1; wr_idx = 8'd9; wr_data = 8'hF0;
        @(negedge clk);
        wr_stb = 1'b0;
        check("R6 err set", {7'd0, err_pulse}, 8'd1);
        @(negedge clk);
        check("R6 err cleared", {7'd0, err_pulse}, 8'd0);

        // R5 and R4: reset restores defaults and clears seen flags
        rst_n = 1'b0;
        #1;
        check_read("R5 re idx0", 8'd0, 4'h5, 4'h0);
        check_read("R4 re idx2", 8'd2, 4'h0, 4'h0);
        check_read("R5 re idx3", 8'd3, 4'hA, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 repeated from fresh defaults
        wr_stb = 1'b1; wr_idx = 8'd2;
        wr_data = 8'h11; @(negedge clk);
        wr_data = 8'h23; @(negedge clk);
        wr_data = 8'h47; @(negedge clk);
        wr_stb = 1'b0;
        check_read("R3 accumulated", 8'd2, 4'h7, 4'h7);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule